// File: doc/BRIEF.md
# Adaptive Prefetch Slip Control Queue

This block couples a prefetch engine to a load engine through a token queue. The prefetch side pushes one token for each prefetch iteration, and the load side pops one token for each load iteration. A load-side pop waits while the queue is empty. A prefetch-side push waits while the queue holds as many tokens as the current slip limit allows. The slip limit therefore sets how far prefetching may run ahead of the loads.

An eight-entry tracker records the prefetched lines that are still outstanding. A prefetch issue takes an entry. A fill event marks the entry as arrived. A load lookup releases the entry and classifies it: useful if its fill had already arrived, late if it had not. After each fixed number of loads, an adaptation controller moves the limit up or down by one, based on the late and useful counts. It holds the limit while the tracker is full. Memory and cache arrays are not part of the block.

Top module: `slip_ctrl_queue`

## Requirements
- R1: After reset the slip limit equals INIT_SLIP, the queue is empty (`get_valid`=0, `occupancy`=0), `put_ready`=1, the tracker is empty (`pf_full`=0), and `lk_hit`=`lk_late`=0.
- R2: `put_ready` is 1 exactly when occupancy is below the current limit. A push takes effect only when `put_valid` and `put_ready` are both 1. With `put_valid` high and `put_ready` low, occupancy does not grow.
- R3: Tokens leave in the order they entered. `get_valid` is 1 exactly when occupancy is nonzero. A pop (`get_ready` with `get_valid`) and a push in the same cycle leave occupancy unchanged.
- R4: The tracker holds PF_ENTRIES (default 8) lines. A prefetch issue takes the lowest free entry. `pf_full` is 1 when every entry is taken. An issue made while full is dropped, so a later lookup of that address misses.
- R5: A load lookup matches the lowest-index taken entry that holds the same address. It releases that entry. One cycle later it reports `lk_hit`=1, with `lk_late`=1 if the fill had not yet arrived and `lk_late`=0 if it had. A lookup with no match reports `lk_hit`=0, `lk_late`=0.
- R6: A fill event marks every taken entry that holds its address as arrived. A fill that matches no entry has no effect. A fill and a lookup of the same entry in the same cycle count as late.
- R7: Every EPOCH lookups (cycles with `ld_valid`=1, whether hit or miss), the controller evaluates once. The evaluation includes the classification from the lookup in that same cycle. The late and useful counts then clear.
- R8: At an evaluation the limit holds if `pf_full` was 1 at the start of that cycle. Otherwise it rises by one when twice the late count exceeds the useful count, and falls by one in every other case. The new limit is visible on `slip_limit` right after that clock edge.
- R9: The limit never leaves the range 1 to MAX_SLIP. A rise at MAX_SLIP and a fall at 1 leave the limit unchanged.
- R10: When the limit falls below the current occupancy, no token is lost. `put_ready` stays 0 until pops bring occupancy below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| put_valid | input | 1 | Prefetch side offers a token |
| put_token | input | TOKEN_W | Token value pushed |
| put_ready | output | 1 | Queue accepts a push this cycle |
| get_valid | output | 1 | A token is available |
| get_token | output | TOKEN_W | Oldest token |
| get_ready | input | 1 | Load side pops the oldest token |
| pf_issue_valid | input | 1 | A prefetch was issued |
| pf_issue_addr | input | ADDR_W | Line address of the issued prefetch |
| pf_fill_valid | input | 1 | A prefetch fill arrived |
| pf_fill_addr | input | ADDR_W | Line address of the fill |
| ld_valid | input | 1 | A load was issued (lookup) |
| ld_addr | input | ADDR_W | Line address of the load |
| lk_hit | output | 1 | Previous cycle's lookup matched an entry |
| lk_late | output | 1 | Previous cycle's matched entry had not been filled |
| pf_full | output | 1 | All tracker entries are taken |
| slip_limit | output | LIM_W | Current slip limit |
| occupancy | output | LIM_W | Tokens held in the queue |

## Verification
The hardest state to reach is an evaluation that happens while the tracker is full, since a full tracker normally sees hits that release entries. The bench first fills all eight entries. It then adds one dropped issue and runs a whole epoch of lookups to addresses that are not held. Under the decision rule, those zero counts would otherwise lower the limit, so a held limit shows the rule was applied. A second situation that is hard to reach is a limit that shrinks under a full queue. The bench first raises the limit with late-only epochs, fills the queue, and then runs a useful-only epoch. A reference model in the bench mirrors the tracker and the epoch counts and predicts every lookup result and every limit step.

// File: rtl/slipq_pkg.sv
// Package: shared types for the slip control queue.
// Assumes: nothing beyond IEEE 1800-2017.
package slipq_pkg;

    // Result of one load lookup into the prefetch tracker.
    typedef struct packed {
        logic hit;
        logic late;
    } lookup_t;

    // Decision taken by the adaptation controller at an evaluation point.
    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adjust_e;

endpackage

// File: rtl/slipq_token_fifo.sv
// Module: token FIFO whose accepting depth is capped by a run-time limit.
// Physical storage is MAX_SLIP entries. put_ready is low while occupancy
// is at or above the limit. A shrinking limit never drops tokens.
// Assumes: limit is within 1..MAX_SLIP.
module slipq_token_fifo #(
    parameter int MAX_SLIP = 16,
    parameter int TOKEN_W  = 8,
    localparam int LIM_W   = $clog2(MAX_SLIP + 1),
    localparam int PTR_W   = (MAX_SLIP > 1) ? $clog2(MAX_SLIP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               put_valid,
    input  logic [TOKEN_W-1:0] put_token,
    output logic               put_ready,
    output logic               get_valid,
    output logic [TOKEN_W-1:0] get_token,
    input  logic               get_ready,
    input  logic [LIM_W-1:0]   limit,
    output logic [LIM_W-1:0]   occ
);

    logic [TOKEN_W-1:0] store_q [MAX_SLIP];
    logic [PTR_W-1:0]   wr_ptr_q;
    logic [PTR_W-1:0]   rd_ptr_q;
    logic [LIM_W-1:0]   occ_q;
    logic               push;
    logic               pop;

    // Handshake qualification against the current limit.
    always_comb begin
        put_ready = (occ_q < limit);
        get_valid = (occ_q != '0);
        push      = put_valid && put_ready;
        pop       = get_ready && get_valid;
        get_token = store_q[rd_ptr_q];
        occ       = occ_q;
    end

    // Token storage write.
    always_ff @(posedge clk) begin
        if (push) begin
            store_q[wr_ptr_q] <= put_token;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_W'(MAX_SLIP - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_W'(MAX_SLIP - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            if (push && !pop) begin
                occ_q <= occ_q + 1'b1;
            end else if (pop && !push) begin
                occ_q <= occ_q - 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= LIM_W'(MAX_SLIP)); // R2
    AST_PUT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (put_valid && occ_q >= limit) |=> occ_q <= $past(occ_q)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (get_ready && occ_q == '0) |=> occ_q <= LIM_W'(1)); // R3

endmodule

// File: rtl/slipq_pf_tracker.sv
// Module: tracker of outstanding prefetched lines.
// Each entry holds a line address, a taken flag and an arrived flag.
// An issue takes the lowest free entry and is dropped when full. A fill
// marks matching entries as arrived. A lookup releases the lowest matching
// entry and classifies it as late (not arrived) or useful (arrived).
// Assumes: at most one issue, one fill and one lookup per cycle.
module slipq_pf_tracker
    import slipq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              full,
    output lookup_t           result
);

    logic              taken_q   [ENTRIES];
    logic              arrived_q [ENTRIES];
    logic [ADDR_W-1:0] addr_q    [ENTRIES];
    logic [ENTRIES-1:0] taken_vec;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  hit_idx;
    logic              any_free;
    logic              any_hit;

    // Lowest free entry and lowest matching entry for the lookup.
    always_comb begin
        any_free = 1'b0;
        any_hit  = 1'b0;
        free_idx = '0;
        hit_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            taken_vec[i] = taken_q[i];
            if (!taken_q[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (taken_q[i] && addr_q[i] == ld_addr) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        full        = !any_free;
        result.hit  = ld_valid && any_hit;
        result.late = ld_valid && any_hit && !arrived_q[hit_idx];
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            logic alloc_here;
            logic free_here;
            logic fill_here;

            // Per-entry event decode.
            always_comb begin
                alloc_here = iss_valid && any_free && (free_idx == IDX_W'(g));
                free_here  = result.hit && (hit_idx == IDX_W'(g));
                fill_here  = fill_valid && taken_q[g] && (addr_q[g] == fill_addr);
            end

            // Per-entry state update; allocation wins over other events.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    taken_q[g]   <= 1'b0;
                    arrived_q[g] <= 1'b0;
                    addr_q[g]    <= '0;
                end else if (alloc_here) begin
                    taken_q[g]   <= 1'b1;
                    arrived_q[g] <= 1'b0;
                    addr_q[g]    <= iss_addr;
                end else if (free_here) begin
                    taken_q[g]   <= 1'b0;
                    arrived_q[g] <= 1'b0;
                end else if (fill_here) begin
                    arrived_q[g] <= 1'b1;
                end
            end
        end
    endgenerate

    AST_FULL_DROPS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !result.hit) |=> full); // R4
    AST_LOOKUP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (result.hit && !iss_valid) |=>
        ($countones(taken_vec) + 1 == $past($countones(taken_vec)))); // R5

endmodule

// File: rtl/slipq_adapt_ctrl.sv
// Module: slip limit adaptation controller.
// Counts late and useful lookups over an epoch of EPOCH lookups. At the
// last lookup of the epoch it holds the limit when the tracker was full,
// otherwise steps it up when 2*late > useful and down otherwise, clamped
// to 1..MAX_SLIP. Counts clear after each evaluation.
// Assumes: EPOCH >= 2, INIT_SLIP within 1..MAX_SLIP.
module slipq_adapt_ctrl
    import slipq_pkg::*;
#(
    parameter int MAX_SLIP  = 16,
    parameter int INIT_SLIP = 4,
    parameter int EPOCH     = 32,
    localparam int LIM_W    = $clog2(MAX_SLIP + 1),
    localparam int EP_W     = $clog2(EPOCH),
    localparam int CNT_W    = $clog2(EPOCH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  lookup_t          result,
    input  logic             pf_full,
    output logic [LIM_W-1:0] limit
);

    logic [EP_W-1:0]  ep_cnt_q;
    logic [CNT_W-1:0] late_q;
    logic [CNT_W-1:0] useful_q;
    logic [CNT_W-1:0] late_n;
    logic [CNT_W-1:0] useful_n;
    logic [LIM_W-1:0] lim_q;
    logic             evaluate;
    adjust_e          adj;

    // Running counts including this cycle's lookup, and the decision.
    always_comb begin
        late_n   = late_q + CNT_W'(result.hit && result.late);
        useful_n = useful_q + CNT_W'(result.hit && !result.late);
        evaluate = ld_valid && (ep_cnt_q == EP_W'(EPOCH - 1));
        if (pf_full) begin
            adj = ADJ_HOLD;
        end else if ({late_n, 1'b0} > {1'b0, useful_n}) begin
            adj = ADJ_UP;
        end else begin
            adj = ADJ_DOWN;
        end
        limit = lim_q;
    end

    // Epoch counter and classification counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_cnt_q <= '0;
            late_q   <= '0;
            useful_q <= '0;
        end else if (evaluate) begin
            ep_cnt_q <= '0;
            late_q   <= '0;
            useful_q <= '0;
        end else if (ld_valid) begin
            ep_cnt_q <= ep_cnt_q + 1'b1;
            late_q   <= late_n;
            useful_q <= useful_n;
        end
    end

    // Limit register with clamping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= LIM_W'(INIT_SLIP);
        end else if (evaluate) begin
            case (adj)
                ADJ_UP:   if (lim_q < LIM_W'(MAX_SLIP)) lim_q <= lim_q + 1'b1;
                ADJ_DOWN: if (lim_q > LIM_W'(1))        lim_q <= lim_q - 1'b1;
                default:  lim_q <= lim_q;
            endcase
        end
    end

    AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q >= LIM_W'(1)) && (lim_q <= LIM_W'(MAX_SLIP))); // R9
    AST_LIMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lim_q == $past(lim_q)) || (lim_q == $past(lim_q) + 1'b1) ||
                 (lim_q + 1'b1 == $past(lim_q))); // R8
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (evaluate && pf_full) |=> $stable(lim_q)); // R8
    AST_ONLY_AT_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !evaluate |=> $stable(lim_q)); // R7

endmodule

// File: rtl/slip_ctrl_queue.sv
// Module: top of the adaptive slip control queue.
// Joins the token FIFO, the prefetch tracker and the adaptation controller,
// and registers the lookup result as a one-cycle-late status.
// Assumes: a single clock domain and synchronous active-low reset.
module slip_ctrl_queue
    import slipq_pkg::*;
#(
    parameter int MAX_SLIP   = 16,
    parameter int INIT_SLIP  = 4,
    parameter int EPOCH      = 32,
    parameter int PF_ENTRIES = 8,
    parameter int TOKEN_W    = 8,
    parameter int ADDR_W     = 16,
    localparam int LIM_W     = $clog2(MAX_SLIP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               put_valid,
    input  logic [TOKEN_W-1:0] put_token,
    output logic               put_ready,
    output logic               get_valid,
    output logic [TOKEN_W-1:0] get_token,
    input  logic               get_ready,
    input  logic               pf_issue_valid,
    input  logic [ADDR_W-1:0]  pf_issue_addr,
    input  logic               pf_fill_valid,
    input  logic [ADDR_W-1:0]  pf_fill_addr,
    input  logic               ld_valid,
    input  logic [ADDR_W-1:0]  ld_addr,
    output logic               lk_hit,
    output logic               lk_late,
    output logic               pf_full,
    output logic [LIM_W-1:0]   slip_limit,
    output logic [LIM_W-1:0]   occupancy
);

    lookup_t          lk_res;
    logic [LIM_W-1:0] limit;

    slipq_token_fifo #(
        .MAX_SLIP (MAX_SLIP),
        .TOKEN_W  (TOKEN_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .put_valid (put_valid),
        .put_token (put_token),
        .put_ready (put_ready),
        .get_valid (get_valid),
        .get_token (get_token),
        .get_ready (get_ready),
        .limit     (limit),
        .occ       (occupancy)
    );

    slipq_pf_tracker #(
        .ENTRIES (PF_ENTRIES),
        .ADDR_W  (ADDR_W)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (pf_issue_valid),
        .iss_addr   (pf_issue_addr),
        .fill_valid (pf_fill_valid),
        .fill_addr  (pf_fill_addr),
        .ld_valid   (ld_valid),
        .ld_addr    (ld_addr),
        .full       (pf_full),
        .result     (lk_res)
    );

    slipq_adapt_ctrl #(
        .MAX_SLIP  (MAX_SLIP),
        .INIT_SLIP (INIT_SLIP),
        .EPOCH     (EPOCH)
    ) u_adapt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .result   (lk_res),
        .pf_full  (pf_full),
        .limit    (limit)
    );

    // Expose the limit.
    always_comb slip_limit = limit;

    // Register the lookup classification for the status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_late <= 1'b0;
        end else begin
            lk_hit  <= lk_res.hit;
            lk_late <= lk_res.late;
        end
    end

    AST_LATE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_late |-> lk_hit); // R5
    AST_NO_LOOKUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !lk_hit); // R5

endmodule

// File: tb/slip_ctrl_queue_bench.sv
module slip_ctrl_queue_bench;

    localparam int MAXS  = 4;
    localparam int INIT  = 2;
    localparam int EPO   = 4;
    localparam int NPF   = 8;
    localparam int LW    = $clog2(MAXS + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic put_valid, get_ready, pf_issue_valid, pf_fill_valid, ld_valid;
    logic [7:0] put_token, pf_issue_addr, pf_fill_addr, ld_addr;
    logic put_ready, get_valid, lk_hit, lk_late, pf_full;
    logic [7:0] get_token;
    logic [LW-1:0] slip_limit, occupancy;

    int total = 0;
    int bad = 0;

    // reference model state
    bit m_v [NPF];
    bit m_f [NPF];
    int m_a [NPF];
    int m_lim, m_cnt, m_late, m_use;

    always #5 clk = ~clk;

    slip_ctrl_queue #(
        .MAX_SLIP(MAXS), .INIT_SLIP(INIT), .EPOCH(EPO),
        .PF_ENTRIES(NPF), .TOKEN_W(8), .ADDR_W(8)
    ) u_slip_ctrl_queue (
        .clk(clk), .rst_n(rst_n),
        .put_valid(put_valid), .put_token(put_token), .put_ready(put_ready),
        .get_valid(get_valid), .get_token(get_token), .get_ready(get_ready),
        .pf_issue_valid(pf_issue_valid), .pf_issue_addr(pf_issue_addr),
        .pf_fill_valid(pf_fill_valid), .pf_fill_addr(pf_fill_addr),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .lk_hit(lk_hit), .lk_late(lk_late), .pf_full(pf_full),
        .slip_limit(slip_limit), .occupancy(occupancy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic bit m_full();
        for (int i = 0; i < NPF; i++) if (!m_v[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic pf_issue(input int a);
        pf_issue_valid = 1'b1; pf_issue_addr = 8'(a);
        tick();
        pf_issue_valid = 1'b0;
        if (!m_full()) begin
            for (int i = 0; i < NPF; i++) begin
                if (!m_v[i]) begin
                    m_v[i] = 1'b1; m_f[i] = 1'b0; m_a[i] = a;
                    break;
                end
            end
        end
        chk(pf_full == m_full(), "R4 pf_full", pf_full, m_full());
    endtask

    task automatic pf_fill(input int a);
        pf_fill_valid = 1'b1; pf_fill_addr = 8'(a);
        tick();
        pf_fill_valid = 1'b0;
        for (int i = 0; i < NPF; i++) if (m_v[i] && m_a[i] == a) m_f[i] = 1'b1;
    endtask

    // one lookup; model predicts hit/late and limit step
    task automatic load(input int a, input string tag);
        bit was_full, hit, late;
        was_full = m_full();
        hit = 1'b0; late = 1'b0;
        for (int i = 0; i < NPF; i++) begin
            if (m_v[i] && m_a[i] == a) begin
                hit = 1'b1; late = !m_f[i]; m_v[i] = 1'b0;
                break;
            end
        end
        if (hit && late) m_late++;
        if (hit && !late) m_use++;
        m_cnt++;
        if (m_cnt == EPO) begin
            if (!was_full) begin
                if (2 * m_late > m_use) m_lim = (m_lim < MAXS) ? m_lim + 1 : MAXS;
                else m_lim = (m_lim > 1) ? m_lim - 1 : 1;
            end
            m_cnt = 0; m_late = 0; m_use = 0;
        end
        ld_valid = 1'b1; ld_addr = 8'(a);
        tick();
        ld_valid = 1'b0;
        chk(lk_hit == hit, {"R5 lk_hit ", tag}, lk_hit, hit);
        chk(lk_late == late, {"R5 lk_late ", tag}, lk_late, late);
        chk(int'(slip_limit) == m_lim, {"R8 R9 limit ", tag}, slip_limit, m_lim);
    endtask

    // one epoch made of nl late and nu useful lookups (nl+nu == EPO)
    task automatic epoch(input int nl, input int nu);
        for (int k = 0; k < nl; k++) begin
            pf_issue(16 + k);
            load(16 + k, "late R7");
        end
        for (int k = 0; k < nu; k++) begin
            pf_issue(32 + k);
            pf_fill(32 + k);
            load(32 + k, "useful R7");
        end
    endtask

    task automatic put(input int t);
        put_valid = 1'b1; put_token = 8'(t);
        tick();
        put_valid = 1'b0;
    endtask

    task automatic get_exp(input int t, input string tag);
        chk(get_valid == 1'b1, {"R3 get_valid ", tag}, get_valid, 1);
        chk(int'(get_token) == t, {"R3 order ", tag}, get_token, t);
        get_ready = 1'b1;
        tick();
        get_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        put_valid = 0; get_ready = 0; pf_issue_valid = 0; pf_fill_valid = 0; ld_valid = 0;
        put_token = 0; pf_issue_addr = 0; pf_fill_addr = 0; ld_addr = 0;
        for (int i = 0; i < NPF; i++) begin m_v[i] = 0; m_f[i] = 0; m_a[i] = 0; end
        m_lim = INIT; m_cnt = 0; m_late = 0; m_use = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk(int'(slip_limit) == INIT, "R1 limit", slip_limit, INIT);
        chk(get_valid == 0, "R1 get_valid", get_valid, 0);
        chk(occupancy == 0, "R1 occupancy", occupancy, 0);
        chk(put_ready == 1, "R1 put_ready", put_ready, 1);
        chk(pf_full == 0, "R1 pf_full", pf_full, 0);
        chk(lk_hit == 0 && lk_late == 0, "R1 lookup status", lk_hit, 0);

        // R2 fill to limit, blocked put does not grow occupancy
        put(8'hA1);
        put(8'hA2);
        chk(put_ready == 0, "R2 put_ready at limit", put_ready, 0);
        put(8'hA3);
        chk(occupancy == 2, "R2 blocked put", occupancy, 2);
        get_exp(8'hA1, "first");
        // R3 simultaneous put and pop
        put_valid = 1; put_token = 8'hA4; get_ready = 1;
        chk(get_token == 8'hA2, "R3 order head", get_token, 8'hA2);
        tick();
        put_valid = 0; get_ready = 0;
        chk(occupancy == 1, "R3 put+pop occupancy", occupancy, 1);
        get_exp(8'hA4, "after put+pop");
        chk(get_valid == 0, "R3 empty", get_valid, 0);

        // R7 R8 R9 sweep over every late/useful split of an epoch
        for (int nl = EPO; nl >= 0; nl--) epoch(nl, EPO - nl);
        epoch(0, EPO);
        epoch(0, EPO);
        chk(int'(slip_limit) == 1, "R9 floor", slip_limit, 1);
        epoch(EPO, 0); epoch(EPO, 0); epoch(EPO, 0); epoch(EPO, 0);
        chk(int'(slip_limit) == MAXS, "R9 ceiling", slip_limit, MAXS);
        // lookups that miss still count toward the epoch (R7)
        load(200, "miss R7"); load(201, "miss R7"); load(202, "miss R7"); load(203, "miss R7");

        // R10 shrink below occupancy: limit currently 3
        for (int t = 0; t < int'(slip_limit); t++) put(8'hB0 + t);
        chk(occupancy == 3, "R10 filled", occupancy, 3);
        epoch(0, EPO);
        chk(int'(slip_limit) == 2, "R10 shrunk", slip_limit, 2);
        chk(occupancy == 3 && put_ready == 0, "R10 no drop", occupancy, 3);
        get_exp(8'hB0, "R10");
        chk(put_ready == 0, "R10 still blocked", put_ready, 0);
        get_exp(8'hB1, "R10");
        chk(put_ready == 1, "R10 unblocked", put_ready, 1);
        get_exp(8'hB2, "R10");

        // R4 R8 full tracker holds the limit
        for (int k = 0; k < NPF; k++) pf_issue(64 + k);
        chk(pf_full == 1, "R4 full", pf_full, 1);
        pf_issue(99);
        load(210, "full hold R8"); load(211, "full hold R8");
        load(212, "full hold R8"); load(213, "full hold R8");
        load(99, "dropped issue R4");
        // R6 fill marks arrival; same-cycle fill and lookup counts late
        pf_fill(65);
        load(65, "filled R6");
        pf_fill_valid = 1; pf_fill_addr = 8'd66;
        load(66, "same cycle R6");
        pf_fill_valid = 0;
        pf_fill(120);
        pf_issue(120);
        load(120, "stray fill R6");
        for (int k = 0; k < NPF; k++) load(64 + k, "drain");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule